// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block is an asynchronous serial transmitter. Every frame it sends carries one extra bit after the data bits. That bit labels the frame as either an address (ID) frame or an ordinary data frame, so that receivers on a shared line can pick out the frames addressed to them. The host works through a holding register and a small set of flags:

- a data-empty flag that tells the host when it may write the next byte;
- a commit action that clears the data-empty flag and releases the written byte for transmission;
- an end flag that reports when the line has drained.

A level input selects the kind of each frame. The transmitter samples that input at the moment the byte moves from the holding register into the shift register, not at the moment the host writes the byte.

When transmit is enabled, the line first stays at mark for one whole frame time before any frame may start. When transmit is disabled, the line follows a separate port-data input, so the host can hold a continuous break by driving that input low. Bit timing comes from a clock-enable divider followed by a fixed number of ticks per bit.

Top module: `mpu_tx_top`

## Requirements
- R1: A frame has 11 bits: start bit 0, then the 8 data bits with the LSB first, then the multiprocessor bit, then stop bit 1. Each bit lasts OVS*BAUD_DIV clock cycles, measured from the load cycle. The line is 1 whenever no frame is being sent.
- R2: The multiprocessor bit of a frame equals `mp_ctl` as sampled in the cycle of the transfer into the shift register (1 = ID frame, 0 = data frame). The value of `mp_ctl` when the byte was written has no effect.
- R3: After `tx_en` rises, `txd` stays 1 for 11 bit times. A frame that was committed earlier starts no sooner than that, and no later than 3 cycles after it.
- R4: A write is accepted only while `empty_flag` is 1. A write while `empty_flag` is 0 leaves the held byte unchanged. `empty_flag` returns to 1 one cycle after the byte moves into the shift register.
- R5: A pulse on `empty_clr` sets `empty_flag` to 0 and commits the held byte. A byte that is written but never committed is not sent.
- R6: `end_flag` is 1 after reset. An accepted write clears it. It goes to 1 again within 3 cycles after the stop bit of a frame ends, provided no committed byte is waiting. It stays 0 while that stop bit is being sent.
- R7: If a byte is committed while a frame is being sent, its start bit begins right after the current stop bit. The two start edges are then exactly one frame time apart.
- R8: While `tx_en` is 0, `txd` equals `port_bit`, including a continuous 0 for break. Any frame in progress is abandoned. Both `empty_flag` and `end_flag` are forced to 1. Re-enabling does not resume an abandoned frame.
- R9: `empty_irq` equals `empty_flag` AND `irq_en`.
- R10: After reset, `empty_flag` is 1, `end_flag` is 1, and `txd` follows `port_bit` while `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| port_bit | input | 1 | Line value while transmit is disabled |
| mp_ctl | input | 1 | Frame kind: 1 = ID, 0 = data; sampled at transfer |
| irq_en | input | 1 | Enables the data-empty interrupt |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to hold |
| empty_clr | input | 1 | Clears the data-empty flag (commit) |
| empty_flag | output | 1 | Holding register may be written |
| end_flag | output | 1 | Transmission complete |
| empty_irq | output | 1 | Data-empty interrupt |
| txd | output | 1 | Serial output line |

## Verification
The embedded assertions check, on every cycle, the rules that relate separate pieces of logic:
- a transfer happens only for a committed byte;
- the data-empty flag rises right after each transfer;
- the multiprocessor bit placed in the frame matches the control input at transfer;
- an accepted write drops the end flag;
- disabling transmit forces both flags to 1;
- the bit counter stays inside the frame.

The directed scenarios cover what only the line can show:
- the bit order and bit timing of a decoded frame;
- the warm-up interval after enabling;
- the gap-free spacing of back-to-back frames;
- that a late change of the control input, rather than the value at write time, decides the frame kind;
- that ignored writes do not disturb the next frame;
- that a frame cut off by a disable is not resumed.

// File: rtl/mpu_tx_pkg.sv
package mpu_tx_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WARM  = 2'd1,
        ST_IDLE  = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_e;

    // start + data + multiprocessor bit + stop
    function automatic int frame_len(input int data_w);
        return data_w + 3;
    endfunction

endpackage

// File: rtl/mpu_tx_baud.sv
module mpu_tx_baud #(
    parameter int BAUD_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sync_i,
    output logic tick_o
);
    localparam int CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } baud_t;

    baud_t q, d;

    assign tick_o = run_i && (q.cnt == LAST);

    always_comb begin
        d = q;
        if (!run_i || sync_i) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mpu_tx_host.sv
module mpu_tx_host #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              done_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              empty_o,
    output logic              end_o
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              endf;
    } host_t;

    host_t q, d;

    assign hold_o  = q.hold;
    assign empty_o = q.empty;
    assign end_o   = q.endf;

    always_comb begin
        d = q;
        if (wr_i && q.empty) begin
            d.hold = wr_data_i;
            d.endf = 1'b0;
        end
        if (clr_i)  d.empty = 1'b0;
        if (load_i) d.empty = 1'b1;
        if (done_i) d.endf  = 1'b1;
        if (!tx_en_i) begin
            d.empty = 1'b1;
            d.endf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hold  <= '0;
            q.empty <= 1'b1;
            q.endf  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R4: the transfer frees the holding register on the next cycle
    assert_empty_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> q.empty);

    // R6: an accepted write drops the end flag
    assert_end_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && wr_i && q.empty && !done_i) |=> !q.endf);

    // R8: disabled transmitter reports empty and finished
    assert_disable_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (q.empty && q.endf));

endmodule

// File: rtl/mpu_tx_shifter.sv
module mpu_tx_shifter
    import mpu_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              tick_i,
    input  logic              pending_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mp_i,
    output logic              load_o,
    output logic              done_o,
    output logic              sync_o,
    output logic              line_o
);
    localparam int FW = frame_len(DATA_W);
    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(FW);
    localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(FW - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [TW-1:0] tick_cnt;
        logic [BW-1:0] bit_cnt;
        logic [FW-1:0] sh;
    } shf_t;

    shf_t q, d;
    logic bit_end;
    logic last_bit;
    logic [FW-1:0] new_frame;

    assign bit_end   = tick_i && (q.tick_cnt == TICK_LAST);
    assign last_bit  = (q.bit_cnt == BIT_LAST);
    assign new_frame = {1'b1, mp_i, data_i, 1'b0};
    assign line_o    = q.sh[0];

    always_comb begin
        d      = q;
        load_o = 1'b0;
        done_o = 1'b0;
        sync_o = 1'b0;
        case (q.st)
            ST_OFF: begin
                d.sh = '1;
                if (tx_en_i) begin
                    d.st       = ST_WARM;
                    d.tick_cnt = '0;
                    d.bit_cnt  = '0;
                    sync_o     = 1'b1;
                end
            end
            ST_WARM: begin
                if (bit_end) begin
                    d.tick_cnt = '0;
                    if (last_bit) begin
                        d.st      = ST_IDLE;
                        d.bit_cnt = '0;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end else if (tick_i) begin
                    d.tick_cnt = q.tick_cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (pending_i) begin
                    load_o     = 1'b1;
                    sync_o     = 1'b1;
                    d.sh       = new_frame;
                    d.tick_cnt = '0;
                    d.bit_cnt  = '0;
                    d.st       = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_end) begin
                    d.tick_cnt = '0;
                    if (last_bit) begin
                        d.bit_cnt = '0;
                        if (pending_i) begin
                            load_o = 1'b1;
                            sync_o = 1'b1;
                            d.sh   = new_frame;
                        end else begin
                            done_o = 1'b1;
                            d.sh   = '1;
                            d.st   = ST_IDLE;
                        end
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                        d.sh      = {1'b1, q.sh[FW-1:1]};
                    end
                end else if (tick_i) begin
                    d.tick_cnt = q.tick_cnt + 1'b1;
                end
            end
            default: d.st = ST_OFF;
        endcase
        if (!tx_en_i) begin
            d.st       = ST_OFF;
            d.sh       = '1;
            d.tick_cnt = '0;
            d.bit_cnt  = '0;
            load_o     = 1'b0;
            done_o     = 1'b0;
            sync_o     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_OFF;
            q.tick_cnt <= '0;
            q.bit_cnt  <= '0;
            q.sh       <= '1;
        end else begin
            q <= d;
        end
    end

    // R2: the kind bit in the frame is the control value at transfer
    assert_mp_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (q.sh[FW-2] == $past(mp_i)));

    // R1: bit counter never leaves the frame
    assert_bitcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.bit_cnt <= BIT_LAST);

    // R1: a transfer always begins with the start bit on the line
    assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && tx_en_i) |=> !line_o);

endmodule

// File: rtl/mpu_tx_top.sv
module mpu_tx_top #(
    parameter int DATA_W   = 8,
    parameter int BAUD_DIV = 4,
    parameter int OVS      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              port_bit,
    input  logic              mp_ctl,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              empty_irq,
    output logic              txd
);
    logic              tick;
    logic              sync;
    logic              load;
    logic              done;
    logic              line;
    logic [DATA_W-1:0] hold;

    mpu_tx_baud #(.BAUD_DIV(BAUD_DIV)) baud_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tx_en),
        .sync_i (sync),
        .tick_o (tick)
    );

    mpu_tx_host #(.DATA_W(DATA_W)) host_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en),
        .wr_i      (wr_en),
        .wr_data_i (wr_data),
        .clr_i     (empty_clr),
        .load_i    (load),
        .done_i    (done),
        .hold_o    (hold),
        .empty_o   (empty_flag),
        .end_o     (end_flag)
    );

    mpu_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en),
        .tick_i    (tick),
        .pending_i (!empty_flag),
        .data_i    (hold),
        .mp_i      (mp_ctl),
        .load_o    (load),
        .done_o    (done),
        .sync_o    (sync),
        .line_o    (line)
    );

    assign txd       = tx_en ? line : port_bit;
    assign empty_irq = empty_flag & irq_en;

    // R5: only a committed byte is ever transferred
    assert_load_committed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !empty_flag);

    // R6: completion is never reported while a byte waits
    assert_done_only_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> empty_flag);

endmodule

// File: tb/mpu_tx_top_tb_top.sv
module mpu_tx_top_tb_top;
    localparam int DIV   = 2;
    localparam int OVS   = 16;
    localparam int BIT   = DIV * OVS;
    localparam int FRAME = 11 * BIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, port_bit = 1'b1, mp_ctl = 1'b0, irq_en = 1'b1;
    logic wr_en = 1'b0, empty_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic empty_flag, end_flag, empty_irq, txd;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mpu_tx_top #(.DATA_W(8), .BAUD_DIV(DIV), .OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .port_bit(port_bit),
        .mp_ctl(mp_ctl), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
        .empty_clr(empty_clr), .empty_flag(empty_flag), .end_flag(end_flag),
        .empty_irq(empty_irq), .txd(txd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk); empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0;
    endtask

    // waits for a start edge, decodes one frame, returns in the middle of the stop bit
    task automatic recv(output logic [7:0] d, output logic mp, output int t0, output bit ok);
        int n = 0;
        logic st, sp;
        ok = 1'b0; d = '0; mp = 1'b0; t0 = 0;
        while (txd !== 1'b0 && n < 4 * FRAME) begin
            @(negedge clk); n++;
        end
        if (txd !== 1'b0) return;
        t0 = cyc;
        repeat (BIT / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = txd;
        end
        repeat (BIT) @(negedge clk); mp = txd;
        repeat (BIT) @(negedge clk); sp = txd;
        ok = (st == 1'b0) && (sp == 1'b1);
    endtask

    task automatic t_reset();
        chk("R10", "empty after reset", int'(empty_flag), 1);
        chk("R10", "end after reset", int'(end_flag), 1);
        chk("R10", "txd follows port_bit", int'(txd), 1);
        chk("R9", "irq with empty and enabled", int'(empty_irq), 1);
    endtask

    task automatic t_warmup_id_frame();
        logic [7:0] d; logic mp; int t0; bit ok; int c0;
        @(negedge clk); tx_en = 1'b1; c0 = cyc;
        mp_ctl = 1'b1;
        do_write(8'hA5);
        chk("R6", "end dropped by write", int'(end_flag), 0);
        do_commit();
        chk("R5", "empty cleared by commit", int'(empty_flag), 0);
        chk("R3", "line mark during warm-up", int'(txd), 1);
        recv(d, mp, t0, ok);
        chk_rng("R3", "warm-up length", t0 - c0, FRAME, FRAME + 3);
        chk("R1", "frame framing ok", int'(ok), 1);
        chk("R1", "frame data", int'(d), 8'hA5);
        chk("R2", "ID frame kind bit", int'(mp), 1);
        chk("R4", "empty after transfer", int'(empty_flag), 1);
        chk("R6", "end low during stop bit", int'(end_flag), 0);
        repeat (BIT / 2 + 3) @(negedge clk);
        chk("R6", "end set after stop", int'(end_flag), 1);
        chk("R1", "line idles high", int'(txd), 1);
    endtask

    task automatic t_back_to_back();
        logic [7:0] da, db; logic ma, mb; int ta, tb; bit oka, okb;
        mp_ctl = 1'b0;
        do_write(8'h11);
        do_commit();
        fork
            recv(da, ma, ta, oka);
            begin
                repeat (4) @(negedge clk);
                chk("R9", "irq while empty", int'(empty_irq), 1);
                mp_ctl = 1'b1;
                do_write(8'h22);
                do_commit();
                chk("R9", "irq low while byte waits", int'(empty_irq), 0);
                do_write(8'h99);
                repeat (2) @(negedge clk);
                mp_ctl = 1'b0;
            end
        join
        chk("R1", "first frame data", int'(da), 8'h11);
        chk("R2", "data frame kind bit", int'(ma), 0);
        recv(db, mb, tb, okb);
        chk("R1", "second frame framing", int'(okb), 1);
        chk("R4", "ignored write left byte", int'(db), 8'h22);
        chk("R2", "kind taken at transfer", int'(mb), 0);
        chk("R7", "start edges one frame apart", tb - ta, FRAME);
        repeat (BIT) @(negedge clk);
    endtask

    task automatic t_no_commit();
        int lows = 0;
        logic [7:0] d; logic mp; int t0; bit ok;
        mp_ctl = 1'b1;
        do_write(8'h77);
        for (int i = 0; i < 2 * FRAME; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk("R5", "no frame without commit", lows, 0);
        chk("R6", "end stays low after write", int'(end_flag), 0);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R9", "irq masked", int'(empty_irq), 0);
        irq_en = 1'b1;
        do_commit();
        recv(d, mp, t0, ok);
        chk("R5", "committed byte sent", int'(d), 8'h77);
        chk("R2", "ID frame kind held", int'(mp), 1);
        repeat (BIT) @(negedge clk);
    endtask

    task automatic t_break();
        int bad = 0;
        do_write(8'h00);
        do_commit();
        repeat (3 * BIT) @(negedge clk);
        tx_en = 1'b0; port_bit = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "empty forced on disable", int'(empty_flag), 1);
        chk("R8", "end forced on disable", int'(end_flag), 1);
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            if (txd != 1'b0) bad++;
        end
        chk("R8", "continuous break", bad, 0);
        port_bit = 1'b1; tx_en = 1'b1;
        bad = 0;
        for (int i = 0; i < FRAME + BIT; i++) begin
            @(negedge clk);
            if (txd != 1'b1) bad++;
        end
        chk("R8", "abandoned frame not resumed", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_warmup_id_frame();
        t_back_to_back();
        t_no_commit();
        t_break();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule